// File: doc/BRIEF.md
# Sticky ADC Overrange Peak Detector

This block watches the signed output samples of a stereo ADC and sorts the magnitude of each valid sample into one of four zones measured against digital full scale. Each channel holds the highest zone seen so far in a 2-bit sticky code. The code only moves upward until a clear event drops it back to zero.

Samples carry two integer bits of headroom above full scale. With the default 18-bit samples, full scale is 2^15 = 32768, and values above 0 dB can be represented before clipping. The zone limits are the magnitudes for −1 dB, 0 dB and +1 dB, rounded to integers: 29205, 32768 and 36766.

The code is presented inside a 16-bit status word per channel. A write strobe to that word clears it. The data carried by the write is discarded. The code is also cleared by powering down the channel, by the global reset, by the power-down pin, and by the all-conversions-off control bit. While any of these conditions holds, samples are ignored.

Top module: `ovr_peak_stereo`

## Requirements
- R1: The magnitude m of a valid sample s is |s|. For the default width: code 3 if m > 36766, code 2 if 32768 < m <= 36766, code 1 if 29205 <= m <= 32768, code 0 if m < 29205. A valid sample in a clear-free cycle raises the stored code at the next rising clock edge when its zone is higher.
- R2: A valid sample whose zone is equal to or lower than the stored code leaves the code unchanged (sticky peak).
- R3: A write strobe (`wr_l` / `wr_r`) clears that channel's code to 0 at the next edge. A sample in the same cycle is ignored.
- R4: While a channel's power-down input (`pd_l` / `pd_r`) is high, that channel's code is cleared and stays 0 whatever samples arrive.
- R5: `rst_n` low clears both codes to 0 at once, without waiting for a clock edge.
- R6: While `pwrdwn_n` is low or `conv_off` is high, both codes are cleared and stay 0 whatever samples arrive.
- R7: Each status word carries its code in bits [15:14]. Bits [13:0] always read 0.
- R8: The two channels are independent. Samples, writes and power-down on one channel do not change the other channel's code.
- R9: The most negative sample (−131072 by default) saturates to the largest magnitude and gives code 3.
- R10: With the valid strobe low and no clear event, the code holds, whatever value is on the sample input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low global reset |
| pwrdwn_n | input | 1 | Active-low power-down pin; clears both channels while low |
| conv_off | input | 1 | All-conversions-off control bit; clears both channels while high |
| smp_l | input | 18 | Left signed ADC output sample |
| smp_vld_l | input | 1 | Left sample valid |
| smp_r | input | 18 | Right signed ADC output sample |
| smp_vld_r | input | 1 | Right sample valid |
| wr_l | input | 1 | Write strobe to the left status word (clears it) |
| wr_r | input | 1 | Write strobe to the right status word (clears it) |
| pd_l | input | 1 | Left channel power-down |
| pd_r | input | 1 | Right channel power-down |
| status_l | output | 16 | Left status word, code in [15:14] |
| status_r | output | 16 | Right status word, code in [15:14] |

## Verification
The embedded assertions check four things on every cycle:
- a cycle with no clear event never lowers the code;
- any clear event leaves it at zero;
- a higher zone on a valid sample is taken up at the next edge;
- without a valid sample or a clear event, the code stays stable.

Only the bench's scenarios can show the rest:
- the exact zone limits, tested one count either side of 29205, 32768 and 36766;
- saturation of the most negative sample;
- the priority of a write over a simultaneous sample;
- the isolation between left and right;
- the asynchronous effect of the reset before any clock edge.

// File: rtl/ovr_pkg.sv
package ovr_pkg;

  // Zone of a sample magnitude relative to digital full scale
  typedef enum logic [1:0] {
    ZN_LOW  = 2'b00,  // more than 1 dB below full scale
    ZN_NEAR = 2'b01,  // from -1 dB up to full scale
    ZN_OVER = 2'b10,  // above full scale up to +1 dB
    ZN_HIGH = 2'b11   // beyond +1 dB
  } zone_e;

  // Level ratios in unsigned Q24: 10^(-1/20) and 10^(+1/20)
  localparam longint RATIO_M1DB_Q24 = 64'd14952710;
  localparam longint RATIO_P1DB_Q24 = 64'd18824346;

  // Scale full scale by a Q24 ratio, rounding to the nearest integer
  function automatic longint scale_q24(input longint fs, input longint ratio);
    return (fs * ratio + (64'sd1 <<< 23)) >>> 24;
  endfunction

endpackage

// File: rtl/ovr_zone_classify.sv
module ovr_zone_classify #(
  parameter int SAMPLE_W = 18,
  parameter int FS_LOG2  = 15
) (
  input  logic signed [SAMPLE_W-1:0] smp_i,
  output logic [SAMPLE_W-2:0]        mag_o,
  output ovr_pkg::zone_e             zone_o
);
  import ovr_pkg::*;

  localparam int MAG_W = SAMPLE_W - 1;
  localparam longint FS_VAL = 64'sd1 <<< FS_LOG2;
  localparam logic [MAG_W-1:0] TH_M1 = MAG_W'(scale_q24(FS_VAL, RATIO_M1DB_Q24));
  localparam logic [MAG_W-1:0] TH_FS = MAG_W'(FS_VAL);
  localparam logic [MAG_W-1:0] TH_P1 = MAG_W'(scale_q24(FS_VAL, RATIO_P1DB_Q24));
  localparam logic signed [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};

  // Absolute value; the most negative code saturates to the top magnitude
  function automatic logic [MAG_W-1:0] abs_sat(input logic signed [SAMPLE_W-1:0] s);
    logic signed [SAMPLE_W-1:0] neg;
    neg = -s;
    if (s == MOST_NEG)  return '1;
    else if (s[SAMPLE_W-1]) return neg[MAG_W-1:0];
    else                return s[MAG_W-1:0];
  endfunction

  // Magnitude to zone, highest limit first
  function automatic zone_e zone_of(input logic [MAG_W-1:0] m);
    if (m > TH_P1)       return ZN_HIGH;
    else if (m > TH_FS)  return ZN_OVER;
    else if (m >= TH_M1) return ZN_NEAR;
    else                 return ZN_LOW;
  endfunction

  always_comb begin
    mag_o  = abs_sat(smp_i);
    zone_o = zone_of(mag_o);
  end

endmodule

// File: rtl/ovr_peak_hold.sv
module ovr_peak_hold (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr_i,
  input  logic           vld_i,
  input  ovr_pkg::zone_e zone_i,
  output ovr_pkg::zone_e code_o
);
  import ovr_pkg::*;

  zone_e code_q;
  logic  raise_w;

  // A clear wins over a sample in the same cycle
  assign raise_w = vld_i && !clr_i && (zone_i > code_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= ZN_LOW;
    else if (clr_i)   code_q <= ZN_LOW;
    else if (raise_w) code_q <= zone_i;
  end

  assign code_o = code_q;

  // R2
  sticky_no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (code_q >= $past(code_q)));

  // R3
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (code_q == ZN_LOW));

  // R1
  raise_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && !clr_i && (zone_i > code_q)) |=> (code_q == $past(zone_i)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!vld_i && !clr_i) |=> $stable(code_q));

endmodule

// File: rtl/ovr_channel.sv
module ovr_channel #(
  parameter int SAMPLE_W = 18,
  parameter int FS_LOG2  = 15,
  parameter int REG_W    = 16,
  parameter int CODE_LSB = 14
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       glob_clr_i,
  input  logic                       wr_i,
  input  logic                       pd_i,
  input  logic signed [SAMPLE_W-1:0] smp_i,
  input  logic                       vld_i,
  output logic [REG_W-1:0]           status_o
);
  import ovr_pkg::*;

  logic [SAMPLE_W-2:0] mag_w;
  zone_e               zone_w;
  zone_e               code_w;
  logic                clr_evt_w;

  assign clr_evt_w = wr_i || pd_i || glob_clr_i;

  ovr_zone_classify #(.SAMPLE_W(SAMPLE_W), .FS_LOG2(FS_LOG2)) classify_i (
    .smp_i (smp_i),
    .mag_o (mag_w),
    .zone_o(zone_w)
  );

  ovr_peak_hold hold_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (clr_evt_w),
    .vld_i (vld_i),
    .zone_i(zone_w),
    .code_o(code_w)
  );

  always_comb begin
    status_o = '0;
    status_o[CODE_LSB +: 2] = code_w;
  end

  // R9
  always_comb begin
    if (rst_n && (smp_i == {1'b1, {(SAMPLE_W-1){1'b0}}}))
      most_neg_sat_chk: assert (mag_w == '1 && zone_w == ZN_HIGH);
  end

endmodule

// File: rtl/ovr_peak_stereo.sv
module ovr_peak_stereo #(
  parameter int SAMPLE_W = 18,
  parameter int FS_LOG2  = 15,
  parameter int REG_W    = 16,
  parameter int CODE_LSB = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pwrdwn_n,
  input  logic                conv_off,
  input  logic [SAMPLE_W-1:0] smp_l,
  input  logic                smp_vld_l,
  input  logic [SAMPLE_W-1:0] smp_r,
  input  logic                smp_vld_r,
  input  logic                wr_l,
  input  logic                wr_r,
  input  logic                pd_l,
  input  logic                pd_r,
  output logic [REG_W-1:0]    status_l,
  output logic [REG_W-1:0]    status_r
);
  localparam int N_CH = 2;

  logic                glob_clr_w;
  logic [SAMPLE_W-1:0] smp_a [N_CH];
  logic                vld_a [N_CH];
  logic                wr_a  [N_CH];
  logic                pd_a  [N_CH];
  logic [REG_W-1:0]    st_a  [N_CH];

  assign glob_clr_w = !pwrdwn_n || conv_off;

  assign smp_a[0] = smp_l;      assign smp_a[1] = smp_r;
  assign vld_a[0] = smp_vld_l;  assign vld_a[1] = smp_vld_r;
  assign wr_a[0]  = wr_l;       assign wr_a[1]  = wr_r;
  assign pd_a[0]  = pd_l;       assign pd_a[1]  = pd_r;
  assign status_l = st_a[0];
  assign status_r = st_a[1];

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    ovr_channel #(
      .SAMPLE_W(SAMPLE_W), .FS_LOG2(FS_LOG2),
      .REG_W(REG_W), .CODE_LSB(CODE_LSB)
    ) ch_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .glob_clr_i(glob_clr_w),
      .wr_i      (wr_a[c]),
      .pd_i      (pd_a[c]),
      .smp_i     (signed'(smp_a[c])),
      .vld_i     (vld_a[c]),
      .status_o  (st_a[c])
    );
  end

  // R6
  glob_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    glob_clr_w |=> (status_l == '0 && status_r == '0));

  // R7
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_l & ~({{(REG_W-2){1'b0}}, 2'b11} << CODE_LSB)) == '0) &&
    ((status_r & ~({{(REG_W-2){1'b0}}, 2'b11} << CODE_LSB)) == '0));

endmodule

// File: tb/ovr_peak_stereo_tb.sv
module ovr_peak_stereo_tb_top;
  localparam int SW = 18;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic rst_n = 1'b0, pwrdwn_n = 1'b1, conv_off = 1'b0;
  logic [SW-1:0] smp_l = '0, smp_r = '0;
  logic smp_vld_l = 1'b0, smp_vld_r = 1'b0;
  logic wr_l = 1'b0, wr_r = 1'b0, pd_l = 1'b0, pd_r = 1'b0;
  logic [15:0] status_l, status_r;

  ovr_peak_stereo dut_i (
    .clk(clk), .rst_n(rst_n), .pwrdwn_n(pwrdwn_n), .conv_off(conv_off),
    .smp_l(smp_l), .smp_vld_l(smp_vld_l), .smp_r(smp_r), .smp_vld_r(smp_vld_r),
    .wr_l(wr_l), .wr_r(wr_r), .pd_l(pd_l), .pd_r(pd_r),
    .status_l(status_l), .status_r(status_r)
  );

  int checks = 0, errors = 0;
  logic done = 1'b0;
  logic [1:0] mdl_l = 2'd0, mdl_r = 2'd0;
  logic [15:0] ql[$], qr[$];
  string qt[$];

  // Reference model, written from the requirement text
  function automatic int mag_of(input int s);
    if (s == -131072) return 131071;
    return (s < 0) ? -s : s;
  endfunction

  function automatic logic [1:0] zone_of(input int s);
    int m;
    m = mag_of(s);
    if (m > 36766) return 2'd3;
    if (m > 32768) return 2'd2;
    if (m >= 29205) return 2'd1;
    return 2'd0;
  endfunction

  function automatic logic [15:0] word_of(input logic [1:0] c);
    return {c, 14'd0};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: apply one cycle of stimulus and queue the expected words
  task automatic step(input string tag, input int sl, input logic vl, input int sr,
                      input logic vr, input logic wl, input logic wrr, input logic pl,
                      input logic pr, input logic pdn, input logic coff);
    @(negedge clk);
    smp_l = SW'(sl); smp_vld_l = vl; smp_r = SW'(sr); smp_vld_r = vr;
    wr_l = wl; wr_r = wrr; pd_l = pl; pd_r = pr; pwrdwn_n = pdn; conv_off = coff;
    if (wl || pl || !pdn || coff) mdl_l = 2'd0;
    else if (vl && zone_of(sl) > mdl_l) mdl_l = zone_of(sl);
    if (wrr || pr || !pdn || coff) mdl_r = 2'd0;
    else if (vr && zone_of(sr) > mdl_r) mdl_r = zone_of(sr);
    ql.push_back(word_of(mdl_l));
    qr.push_back(word_of(mdl_r));
    qt.push_back(tag);
  endtask

  task automatic both(input string tag, input int sl, input int sr);
    step(tag, sl, 1'b1, sr, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
  endtask

  // Monitor: compare items due after each rising edge
  initial begin
    forever begin
      int n;
      @(posedge clk);
      n = ql.size();
      @(negedge clk);
      #1;
      for (int i = 0; i < n; i++) begin
        string t;
        t = qt.pop_front();
        chk({t, " left"}, status_l, ql.pop_front());
        chk({t, " right"}, status_r, qr.pop_front());
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R5 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R5 reset left", status_l, 16'h0000);
    chk("R7 reset right", status_r, 16'h0000);

    // R1 limits one count either side; right uses negated values
    both("R1 29204", 29204, -29204);
    both("R1 29205", 29205, -29205);
    both("R1 32768", 32768, -32768);
    both("R1 32769", 32769, -32769);
    both("R1 36766", 36766, -36766);
    both("R1 36767", 36767, -36767);
    // R2 lower zones leave the peak in place
    both("R2 small", 100, -5);
    both("R2 mid", 33000, 30000);
    // R3 write clears both
    step("R3 clear", 0, 1'b0, 0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    // R10 large value without valid is ignored
    step("R10 novld", 131071, 1'b0, -131071, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    both("R1 near", 30000, 30000);
    // R3 write beats a same-cycle sample; R8 right keeps going
    step("R3 wr+smp", 36767, 1'b1, 36767, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    // R9 most negative saturates
    step("R9 mostneg", -131072, 1'b1, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    // R4 left power-down holds left at zero; R8 right unaffected
    for (int i = 0; i < 3; i++)
      step("R4 pd_l", 36767, 1'b1, 100, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    step("R4 pd_l off", 29205, 1'b1, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    step("R8 wr_r", 0, 1'b0, 0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    step("R8 pd_r", 0, 1'b0, 40000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    // R6 conversions off, then power-down pin
    step("R6 conv_off", 40000, 1'b1, 40000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    step("R6 conv_off hold", 40000, 1'b1, 40000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    both("R6 resume", 32769, -32769);
    step("R6 pwrdwn", 40000, 1'b1, 40000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step("R6 pwrdwn hold", -131072, 1'b1, 40000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    both("R1 neg high", -40000, 36767);
    // R5 asynchronous reset, checked before any clock edge
    @(negedge clk);
    @(negedge clk);
    smp_vld_l = 1'b0; smp_vld_r = 1'b0;
    #2;
    rst_n = 1'b0;
    #1;
    chk("R5 async left", status_l, 16'h0000);
    chk("R5 async right", status_r, 16'h0000);
    mdl_l = 2'd0; mdl_r = 2'd0;
    @(negedge clk);
    rst_n = 1'b1;
    both("R7 after reset", 29205, 0);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule